// File: doc/BRIEF.md
# Flash Sector Protection Resolver

This block sits between the command decoder and the erase/program sequencer of a 256K-word flash array. For each accepted request it decides which sectors may be erased or whether a word may be programmed. The inputs are a word address, a request kind and a high-voltage override level. The block keeps a boot-lock flag, which a dedicated lock request sets. Only a power-on reset clears the flag, so it stands in for non-volatile state.

The array has four regions, each 8K words or more, found from address bits [17:13]. Value 0 is the boot region (words 0x00000 to 0x01FFF). Value 1 is parameter region 1 and value 2 is parameter region 2. Values 3 to 31 are the main region (232K words). While unlocked, the boot region is erased together with the main region. Once locked, boot content is frozen and chip erase is refused. The override lifts that protection for as long as it is held.

A decision appears on the outputs the cycle after the request is sampled and lasts exactly one cycle. The array storage and the timing of the operations belong to other blocks.

Top module: `flash_prot_resolver`

## Requirements
- R1: After reset, erase_mask is 0, prog_allow and reject are 0, and boot_locked is 0.
- R2: A sector erase whose address bits [17:13] are 1 gives erase_mask 4'b0010, and one whose bits are 2 gives 4'b0100. Mask bit 0 is boot, bit 1 parameter 1, bit 2 parameter 2 and bit 3 main. The result appears one cycle after the request.
- R3: While unlocked, a sector erase addressed into the boot or main region (bits [17:13] equal to 0, or to 3 or more) gives erase_mask 4'b1001.
- R4: While locked, with the override low, a sector erase addressed into the boot or main region gives erase_mask 4'b1000.
- R5: A word program (req_kind 2'b00) into the boot region raises reject with prog_allow low while locked and the override is low. Otherwise a word program gives prog_allow high with reject low.
- R6: A chip erase (req_kind 2'b10) gives erase_mask 4'b1111 while unlocked. While locked with the override low, it gives reject high and erase_mask 0.
- R7: While hv_override is high, a locked block treats all three request kinds as if unlocked. Protection applies again on the first request after hv_override falls.
- R8: A lock request (req_kind 2'b11) sets boot_locked from the following cycle onward, and boot_locked stays set until reset. The lock request itself produces no grant and no reject. Sector erase uses req_kind 2'b01.
- R9: Every decision is a one-cycle pulse. With no request the outputs are zero, and reject never coincides with a nonzero erase_mask or with prog_allow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset, also clears the lock |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 lock |
| req_addr | input | 18 | Word address of the request |
| hv_override | input | 1 | High-voltage override level; lifts boot protection while high |
| erase_mask | output | 4 | Per-sector erase enable pulse: bit0 boot, bit1 param 1, bit2 param 2, bit3 main |
| prog_allow | output | 1 | Word program granted pulse |
| reject | output | 1 | Request refused pulse |
| boot_locked | output | 1 | Current state of the boot-lock flag |

## Verification
The hardest state to reach is a locked block combined with the override. The flag cannot be cleared except by reset, so every locked check must follow an earlier lock request, and unlocked behaviour must be checked first. The bench therefore runs the unlocked scenarios first, then issues the lock request. It then toggles hv_override around chip erase, boot sector erase and boot programming. That sequence shows both that the override restores access and that protection returns on the next request.

// File: rtl/flash_prot_pkg.sv
// Shared types for the flash sector protection resolver.
package flash_prot_pkg;
    typedef enum logic [1:0] {
        REQ_PROG       = 2'b00,
        REQ_SECT_ERASE = 2'b01,
        REQ_CHIP_ERASE = 2'b10,
        REQ_LOCK       = 2'b11
    } req_kind_t;

    typedef enum logic [1:0] {
        RGN_BOOT   = 2'd0,
        RGN_PARAM1 = 2'd1,
        RGN_PARAM2 = 2'd2,
        RGN_MAIN   = 2'd3
    } region_t;

    localparam int NUM_SECT = 4;
endpackage

// File: rtl/fpr_region_decode.sv
// Maps a word address to one of the four protection regions.
// Assumes small regions are 2**SMALL_W words; index 0 boot, 1 and 2
// parameter, anything higher main.
module fpr_region_decode
    import flash_prot_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int SMALL_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region
);
    localparam int IDX_W = ADDR_W - SMALL_W;

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:SMALL_W];

    // Classify the high address bits into a region.
    always_comb begin
        if (idx == IDX_W'(0))      region = RGN_BOOT;
        else if (idx == IDX_W'(1)) region = RGN_PARAM1;
        else if (idx == IDX_W'(2)) region = RGN_PARAM2;
        else                       region = RGN_MAIN;
    end
endmodule

// File: rtl/fpr_lock_store.sv
// Holds the boot-lock flag. Set by a lock request, cleared only by the
// power-on reset, so it stands in for a non-volatile bit.
module fpr_lock_store (
    input  logic clk,
    input  logic rst_n,
    input  logic set_lock,
    output logic locked
);
    // Sticky set, synchronous clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        locked <= 1'b0;
        else if (set_lock) locked <= 1'b1;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R8
    AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_lock |=> locked); // R8
endmodule

// File: rtl/fpr_grant.sv
// Turns a request, its region, the lock flag and the override into a
// registered one-cycle decision: erase mask, program grant or reject.
// Assumes mask bit order boot, param1, param2, main.
module fpr_grant
    import flash_prot_pkg::*;
#(
    parameter int N_SECT = NUM_SECT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  req_kind_t         req_kind,
    input  region_t           region,
    input  logic              locked,
    input  logic              hv_override,
    output logic [N_SECT-1:0] erase_mask,
    output logic              prog_allow,
    output logic              reject
);
    logic              boot_open;
    logic [N_SECT-1:0] mask_nx;
    logic              allow_nx;
    logic              rej_nx;

    assign boot_open = !locked || hv_override;

    // Decide the outcome of the current request.
    always_comb begin
        mask_nx  = '0;
        allow_nx = 1'b0;
        rej_nx   = 1'b0;
        if (req_valid) begin
            unique case (req_kind)
                REQ_PROG: begin
                    if (region == RGN_BOOT && !boot_open) rej_nx   = 1'b1;
                    else                                  allow_nx = 1'b1;
                end
                REQ_SECT_ERASE: begin
                    unique case (region)
                        RGN_PARAM1: mask_nx[RGN_PARAM1] = 1'b1;
                        RGN_PARAM2: mask_nx[RGN_PARAM2] = 1'b1;
                        default: begin
                            mask_nx[RGN_MAIN] = 1'b1;
                            mask_nx[RGN_BOOT] = boot_open;
                        end
                    endcase
                end
                REQ_CHIP_ERASE: begin
                    if (boot_open) mask_nx = '1;
                    else           rej_nx  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Register the decision as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_mask <= '0;
            prog_allow <= 1'b0;
            reject     <= 1'b0;
        end else begin
            erase_mask <= mask_nx;
            prog_allow <= allow_nx;
            reject     <= rej_nx;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (erase_mask == '0 && !prog_allow && !reject)); // R9
    AST_REJECT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (erase_mask == '0 && !prog_allow)); // R9
    AST_BOOT_WITH_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        erase_mask[RGN_BOOT] |-> erase_mask[RGN_MAIN]); // R3
    AST_LOCKED_CHIP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == REQ_CHIP_ERASE && locked && !hv_override)
        |=> (reject && erase_mask == '0)); // R6
    AST_BOOT_PROG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == REQ_PROG && region == RGN_BOOT && locked && !hv_override)
        |=> (!prog_allow && reject)); // R5
    AST_OVERRIDE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == REQ_CHIP_ERASE && hv_override)
        |=> (erase_mask == '1)); // R7
endmodule

// File: rtl/flash_prot_resolver.sv
// Top of the sector protection resolver: region decode, lock flag and
// grant logic. Assumes one request per cycle from the command decoder.
module flash_prot_resolver
    import flash_prot_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int SMALL_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              hv_override,
    output logic [NUM_SECT-1:0] erase_mask,
    output logic              prog_allow,
    output logic              reject,
    output logic              boot_locked
);
    region_t   region;
    req_kind_t kind;
    logic      set_lock;

    assign kind     = req_kind_t'(req_kind);
    assign set_lock = req_valid && kind == REQ_LOCK;

    fpr_region_decode #(.ADDR_W(ADDR_W), .SMALL_W(SMALL_W)) u_decode (
        .addr   (req_addr),
        .region (region)
    );

    fpr_lock_store u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_lock (set_lock),
        .locked   (boot_locked)
    );

    fpr_grant #(.N_SECT(NUM_SECT)) u_grant (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_kind    (kind),
        .region      (region),
        .locked      (boot_locked),
        .hv_override (hv_override),
        .erase_mask  (erase_mask),
        .prog_allow  (prog_allow),
        .reject      (reject)
    );
endmodule

// File: tb/flash_prot_resolver_tb.sv
module flash_prot_resolver_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [17:0] req_addr;
    logic        hv_override;
    logic [3:0]  erase_mask;
    logic        prog_allow;
    logic        reject;
    logic        boot_locked;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [1:0] K_PROG = 2'b00, K_SECT = 2'b01, K_CHIP = 2'b10, K_LOCK = 2'b11;

    always #4 clk = ~clk;

    flash_prot_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .hv_override(hv_override), .erase_mask(erase_mask),
        .prog_allow(prog_allow), .reject(reject), .boot_locked(boot_locked)
    );

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Issue one request, sample its decision, then confirm the pulse ends.
    task automatic issue(input string req, input logic [1:0] k, input logic [17:0] a,
                         input logic hv, input logic [3:0] emask, input logic ep, input logic er);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; hv_override = hv;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {erase_mask, prog_allow, reject}, {emask, ep, er});
        @(negedge clk);
        check("R9", {erase_mask, prog_allow, reject}, 6'b0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_addr = '0; hv_override = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {erase_mask, prog_allow, reject}, 6'b0);
        check("R1", {5'b0, boot_locked}, 6'b0);
    endtask

    task automatic t_unlocked;
        issue("R2", K_SECT, 18'h03123, 1'b0, 4'b0010, 1'b0, 1'b0);
        issue("R2", K_SECT, 18'h05fff, 1'b0, 4'b0100, 1'b0, 1'b0);
        issue("R3", K_SECT, 18'h3F000, 1'b0, 4'b1001, 1'b0, 1'b0);
        issue("R3", K_SECT, 18'h00010, 1'b0, 4'b1001, 1'b0, 1'b0);
        issue("R3", K_SECT, 18'h06000, 1'b0, 4'b1001, 1'b0, 1'b0);
        issue("R5", K_PROG, 18'h01FFF, 1'b0, 4'b0000, 1'b1, 1'b0);
        issue("R6", K_CHIP, 18'h05555, 1'b0, 4'b1111, 1'b0, 1'b0);
    endtask

    task automatic t_lock;
        issue("R8", K_LOCK, 18'h05555, 1'b0, 4'b0000, 1'b0, 1'b0);
        check("R8", {5'b0, boot_locked}, 6'b000001);
    endtask

    task automatic t_locked;
        issue("R4", K_SECT, 18'h3F800, 1'b0, 4'b1000, 1'b0, 1'b0);
        issue("R4", K_SECT, 18'h00000, 1'b0, 4'b1000, 1'b0, 1'b0);
        issue("R2", K_SECT, 18'h03000, 1'b0, 4'b0010, 1'b0, 1'b0);
        issue("R5", K_PROG, 18'h01FFF, 1'b0, 4'b0000, 1'b0, 1'b1);
        issue("R5", K_PROG, 18'h02000, 1'b0, 4'b0000, 1'b1, 1'b0);
        issue("R6", K_CHIP, 18'h05555, 1'b0, 4'b0000, 1'b0, 1'b1);
    endtask

    task automatic t_override;
        issue("R7", K_CHIP, 18'h05555, 1'b1, 4'b1111, 1'b0, 1'b0);
        issue("R7", K_SECT, 18'h3F000, 1'b1, 4'b1001, 1'b0, 1'b0);
        issue("R7", K_PROG, 18'h00004, 1'b1, 4'b0000, 1'b1, 1'b0);
        issue("R7", K_PROG, 18'h00004, 1'b0, 4'b0000, 1'b0, 1'b1);
        issue("R7", K_CHIP, 18'h05555, 1'b0, 4'b0000, 1'b0, 1'b1);
        check("R8", {5'b0, boot_locked}, 6'b000001);
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_unlocked;
                t_lock;
                t_locked;
                t_override;
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule